// File: doc/BRIEF.md
# Configuration and diagnostic register bank

This block holds the configuration state of a two-channel switching transceiver. It also collects that transceiver's diagnostic state, and both are reached through byte-wide register accesses. A serial host front end, which is not part of this block, turns frames into single-cycle write and read strobes with an address and a data byte. Four configuration bytes can be written and read back. Their fields are also driven out as decoded ports to the driver and sense circuitry.

Address 4 is a read-only diagnostic byte that combines two kinds of flag. The first kind is a sticky event flag: a register-reset indication and an input-change indication. Each is cleared when the host reads the diagnostic byte. The second kind is a level fault flag, used for overtemperature, overload on either channel and undervoltage on either supply. A fault flag follows its fault input, and after the fault goes away it stays high for a minimum number of hold ticks, which is 35 ticks of 1 ms by default.

Top module: `cfg_diag_regs`

## Requirements
- R1: After reset the configuration bytes read as follows, with status taken from `in_status`:
  - address 0: 0x1C plus the status in bit 7
  - address 1: 0xF9
  - address 2: 0x19
  - address 3: 0x0B
  The decoded field ports carry the matching values.
- R2: Writes to addresses 0 to 3 take effect on the clock edge where `wr_en` is high. Read-back through `rdata` is combinational from `addr`. The field positions are:
  - address 0: ch_sel in 5:4, ch_en in 3:2, out_data in 1:0
  - address 1: ch2_cfg in 7:6, ch1_cfg in 5:4, pull_en in 3, pol in 2, pull_inv in 1, od_en in 0
  - address 2: chglog_en in 7, req_en in 6, req_ch in 5, ss_en in 4, tx_filt in 3:2, in_filt in 1:0
  - address 3: ch_inv in 5:4, duty in 3:2, exc_en in 1:0
- R3: Bit 7 of address 0 always shows the live `in_status` input, whatever `pol` is set to, and writes do not change it.
- R4: Unused bits read as zero and ignore writes. These are bit 6 of address 0 and bits 7:6 of address 3.
- R5: Diagnostic bit 0, the reset flag, is 1 after reset. A read of address 4 (`rd_en` high) clears it on that clock edge, and the read returns the value from before the clear.
- R6: Diagnostic bit 2, the change flag, is set by a `chg_evt` pulse only while chglog_en is 1. A read of address 4 clears it.
- R7: When a change event that is being logged arrives in the same cycle as a clearing read, the change flag stays set.
- R8: Diagnostic bits are high in the same cycle as their fault input:
  - bit 3 follows `ovt_flt`
  - bits 5:4 follow `ovl_flt[1:0]`
  - bits 7:6 follow `uvd_flt[1:0]`
- R9: Once a fault input goes low, its flag stays high through the next HOLD_TICKS-1 `tick` pulses and drops on the HOLD_TICKS-th pulse. Ticks that arrive while the fault is present do not shorten the hold.
- R10: Writes to address 4 or to any address above 4 change nothing. A read of any address above 4 returns zero.
- R11: Diagnostic bit 1 follows the live `ack_in` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears sticky flags at address 4) |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| in_status | input | 1 | Live sense input status |
| chg_evt | input | 1 | Sense input change event pulse |
| ack_in | input | 1 | Request acknowledged status |
| ovt_flt | input | 1 | Overtemperature fault |
| ovl_flt | input | 2 | Overload fault, channels 2:1 |
| uvd_flt | input | 2 | Undervoltage fault, supplies 2:1 |
| tick | input | 1 | Hold timer tick, one cycle per ms |
| ch_sel | output | 2 | Channel control select |
| ch_en | output | 2 | Channel enable |
| out_data | output | 2 | Channel output data |
| ch2_cfg | output | 2 | Channel 2 configuration |
| ch1_cfg | output | 2 | Channel 1 configuration |
| pull_en | output | 1 | Sense pull current enable |
| pol | output | 1 | Sense polarity inversion |
| pull_inv | output | 1 | Sense pull direction inversion |
| od_en | output | 1 | Open-drain receive output enable |
| chglog_en | output | 1 | Change logging enable |
| req_en | output | 1 | Communication request enable |
| req_ch | output | 1 | Request channel select |
| ss_en | output | 1 | Spread-spectrum oscillator enable |
| tx_filt | output | 2 | Transmit filter configuration |
| in_filt | output | 2 | Sense input filter configuration |
| ch_inv | output | 2 | Channel inversion |
| duty | output | 2 | Overload detection duty configuration |
| exc_en | output | 2 | Excitation current enable |

## Verification
The hardest situation to reach is the exact cycle in which a fault flag falls. That cycle depends on when the fault input fell and on every tick pulse after it. Ticks that arrive while the fault is still present must also leave the hold untouched. The bench drives the tick input itself and pulses it a set number of times, first while a fault is held and then after it is released. It reads the diagnostic byte after HOLD_TICKS-1 pulses and again after HOLD_TICKS pulses. It does this on several fault inputs. The collision of a logged change event with a clearing read is reached directly, and random read, write and event traffic is checked against a bench model of the sticky flags.

// File: rtl/cfg_diag_regs.sv
module cfg_diag_regs #(
  parameter int ADDR_W     = 8,
  parameter int HOLD_TICKS = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              in_status,
  input  logic              chg_evt,
  input  logic              ack_in,
  input  logic              ovt_flt,
  input  logic [1:0]        ovl_flt,
  input  logic [1:0]        uvd_flt,
  input  logic              tick,
  output logic [1:0]        ch_sel,
  output logic [1:0]        ch_en,
  output logic [1:0]        out_data,
  output logic [1:0]        ch2_cfg,
  output logic [1:0]        ch1_cfg,
  output logic              pull_en,
  output logic              pol,
  output logic              pull_inv,
  output logic              od_en,
  output logic              chglog_en,
  output logic              req_en,
  output logic              req_ch,
  output logic              ss_en,
  output logic [1:0]        tx_filt,
  output logic [1:0]        in_filt,
  output logic [1:0]        ch_inv,
  output logic [1:0]        duty,
  output logic [1:0]        exc_en
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam int NFLT  = 5;
  localparam logic [5:0] RST0 = 6'h1C;
  localparam logic [7:0] RST1 = 8'hF9;
  localparam logic [7:0] RST2 = 8'h19;
  localparam logic [5:0] RST3 = 6'h0B;

  logic [5:0] cfg0;
  logic [7:0] cfg1;
  logic [7:0] cfg2;
  logic [5:0] cfg3;
  logic       rst_flag;
  logic       chg_flag;
  logic [NFLT-1:0] flt_in;
  logic [NFLT-1:0] flt_flag;
  logic [7:0] diag;

  wire sel0   = (addr == ADDR_W'(0));
  wire sel1   = (addr == ADDR_W'(1));
  wire sel2   = (addr == ADDR_W'(2));
  wire sel3   = (addr == ADDR_W'(3));
  wire sel4   = (addr == ADDR_W'(4));
  wire rd_clr = rd_en && sel4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= RST0;
      cfg1 <= RST1;
      cfg2 <= RST2;
      cfg3 <= RST3;
    end else if (wr_en) begin
      if (sel0) cfg0 <= wdata[5:0];
      if (sel1) cfg1 <= wdata;
      if (sel2) cfg2 <= wdata;
      if (sel3) cfg3 <= wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_flag <= 1'b1;
      chg_flag <= 1'b0;
    end else begin
      if (rd_clr) rst_flag <= 1'b0;
      if (chg_evt && cfg2[7]) chg_flag <= 1'b1;
      else if (rd_clr)        chg_flag <= 1'b0;
    end
  end

  assign flt_in = {uvd_flt, ovl_flt, ovt_flt};

  for (genvar g = 0; g < NFLT; g++) begin : g_hold
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (flt_in[g])             cnt <= CNT_W'(HOLD_TICKS);
      else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
    end
    assign flt_flag[g] = flt_in[g] || (cnt != '0);
  end

  assign diag = {flt_flag, chg_flag, ack_in, rst_flag};

  always_comb begin
    rdata = 8'h00;
    if (sel0)      rdata = {in_status, 1'b0, cfg0};
    else if (sel1) rdata = cfg1;
    else if (sel2) rdata = cfg2;
    else if (sel3) rdata = {2'b00, cfg3};
    else if (sel4) rdata = diag;
  end

  assign ch_sel    = cfg0[5:4];
  assign ch_en     = cfg0[3:2];
  assign out_data  = cfg0[1:0];
  assign ch2_cfg   = cfg1[7:6];
  assign ch1_cfg   = cfg1[5:4];
  assign pull_en   = cfg1[3];
  assign pol       = cfg1[2];
  assign pull_inv  = cfg1[1];
  assign od_en     = cfg1[0];
  assign chglog_en = cfg2[7];
  assign req_en    = cfg2[6];
  assign req_ch    = cfg2[5];
  assign ss_en     = cfg2[4];
  assign tx_filt   = cfg2[3:2];
  assign in_filt   = cfg2[1:0];
  assign ch_inv    = cfg3[5:4];
  assign duty      = cfg3[3:2];
  assign exc_en    = cfg3[1:0];
endmodule

// File: rtl/cfg_diag_regs_chk.sv
module cfg_diag_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              in_status,
  input logic              chg_evt,
  input logic              chglog_en,
  input logic              ovt_flt,
  input logic [1:0]        uvd_flt,
  input logic [7:0]        diag
);
  a_r3_live_status: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(0)) |-> (rdata[7] == in_status));

  a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(3)) |-> (rdata[7:6] == 2'b00));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(4)) |=> !diag[0]);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(4) && chg_evt && chglog_en) |=> diag[2]);

  a_r8_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
    ovt_flt |-> diag[3]);

  a_r9_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uvd_flt[0]) |-> diag[6]);

  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > ADDR_W'(4)) |-> (rdata == 8'h00));
endmodule

bind cfg_diag_regs cfg_diag_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .in_status(in_status), .chg_evt(chg_evt), .chglog_en(chglog_en),
  .ovt_flt(ovt_flt), .uvd_flt(uvd_flt), .diag(diag)
);

// File: tb/test_cfg_diag_regs.sv
module test_cfg_diag_regs;
  localparam int HOLD = 35;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, in_status = 0, chg_evt = 0, ack_in = 0, ovt_flt = 0, tick = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [1:0] ovl_flt = 0, uvd_flt = 0;
  logic [7:0] rdata;
  logic [1:0] ch_sel, ch_en, out_data, ch2_cfg, ch1_cfg, tx_filt, in_filt, ch_inv, duty, exc_en;
  logic pull_en, pol, pull_inv, od_en, chglog_en, req_en, req_ch, ss_en;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_cfg [4];
  logic m_rst, m_chg;

  always #10 clk = ~clk;

  cfg_diag_regs #(.ADDR_W(8), .HOLD_TICKS(HOLD)) i_cfg_diag_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .in_status(in_status), .chg_evt(chg_evt), .ack_in(ack_in),
    .ovt_flt(ovt_flt), .ovl_flt(ovl_flt), .uvd_flt(uvd_flt), .tick(tick),
    .ch_sel(ch_sel), .ch_en(ch_en), .out_data(out_data), .ch2_cfg(ch2_cfg), .ch1_cfg(ch1_cfg),
    .pull_en(pull_en), .pol(pol), .pull_inv(pull_inv), .od_en(od_en), .chglog_en(chglog_en),
    .req_en(req_en), .req_ch(req_ch), .ss_en(ss_en), .tx_filt(tx_filt), .in_filt(in_filt),
    .ch_inv(ch_inv), .duty(duty), .exc_en(exc_en));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'd0: return {in_status, 1'b0, m_cfg[0][5:0]};
      8'd1: return m_cfg[1];
      8'd2: return m_cfg[2];
      8'd3: return {2'b00, m_cfg[3][5:0]};
      8'd4: return {5'b0, m_chg, ack_in, m_rst};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wmask(logic [7:0] a);
    case (a)
      8'd0, 8'd3: return 8'h3F;
      8'd1, 8'd2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic op(string tag, bit w, bit r, logic [7:0] a, logic [7:0] d, bit c);
    bit set_c;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; chg_evt = c;
    #2;
    if (a == 8'd4) chk({tag, " R5/R6/R11 diag read"}, rdata, exp_rd(a));
    else if (a > 8'd4) chk({tag, " R10 out of range"}, rdata, exp_rd(a));
    else chk({tag, " R2/R3/R4 cfg read"}, rdata, exp_rd(a));
    set_c = c && m_cfg[2][7];
    @(posedge clk);
    if (w && a < 8'd4) m_cfg[a[1:0]] = d & wmask(a);
    if (r && a == 8'd4) begin m_rst = 0; m_chg = 0; end
    if (set_c) m_chg = 1;
    #1;
    wr_en = 0; rd_en = 0; chg_evt = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic peek_diag(string tag, int bitn, bit exp);
    @(negedge clk); addr = 8'd4; rd_en = 0; #2;
    chk(tag, {7'b0, rdata[bitn]}, {7'b0, exp});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_cfg[0] = 8'h1C; m_cfg[1] = 8'hF9; m_cfg[2] = 8'h19; m_cfg[3] = 8'h0B;
    m_rst = 1; m_chg = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); in_status = 1; addr = 0; #2;
    chk("R1 reset addr0", rdata, 8'h9C);
    addr = 1; #1 chk("R1 reset addr1", rdata, 8'hF9);
    addr = 2; #1 chk("R1 reset addr2", rdata, 8'h19);
    addr = 3; #1 chk("R1 reset addr3", rdata, 8'h0B);
    addr = 4; #1 chk("R1 R5 reset diag", rdata, 8'h01);
    chk("R1 fields a", {ch_sel, ch_en, out_data, 2'b00}, 8'b01110000);
    chk("R1 fields b", {ch2_cfg, ch1_cfg, pull_en, pol, pull_inv, od_en}, 8'hF9);
    chk("R1 fields c", {chglog_en, req_en, req_ch, ss_en, tx_filt, in_filt}, 8'h19);
    chk("R1 fields d", {2'b00, ch_inv, duty, exc_en}, 8'h0B);
    // R5 read returns pre-clear value, then cleared
    op("R5 clear", 0, 1, 8'd4, 8'h00, 0);
    op("R5 after", 0, 0, 8'd4, 8'h00, 0);
    // R3 R4 writes to read-only/unused bits
    op("R3 wr0", 1, 0, 8'd0, 8'hFF, 0);
    @(negedge clk); in_status = 0; addr = 0; #2;
    chk("R3 R4 addr0 after ff", rdata, 8'h3F);
    chk("R2 addr0 fields", {ch_sel, ch_en, out_data, 2'b00}, 8'hFC);
    op("R4 wr3", 1, 0, 8'd3, 8'hFF, 0);
    op("R4 rd3", 0, 0, 8'd3, 8'h00, 0);
    op("R2 wr2", 1, 0, 8'd2, 8'h6E, 0);
    chk("R2 addr2 fields", {chglog_en, req_en, req_ch, ss_en, tx_filt, in_filt}, 8'h6E);
    op("R2 wr1", 1, 0, 8'd1, 8'h56, 0);
    chk("R2 addr1 fields", {ch2_cfg, ch1_cfg, pull_en, pol, pull_inv, od_en}, 8'h56);
    @(negedge clk); in_status = 1; addr = 0; #2;
    chk("R3 status with pol=1", rdata[7:0], 8'hBF);
    // R10
    op("R10 wr4", 1, 0, 8'd4, 8'hFF, 0);
    op("R10 wr6", 1, 0, 8'd6, 8'hFF, 0);
    op("R10 rd4", 0, 0, 8'd4, 8'h00, 0);
    op("R10 rd7", 0, 0, 8'd7, 8'h00, 0);
    // R6 gated by log enable (currently 0)
    op("R6 evt off", 0, 0, 8'd4, 8'h00, 1);
    op("R6 check off", 0, 0, 8'd4, 8'h00, 0);
    op("R6 enable", 1, 0, 8'd2, 8'h80, 0);
    op("R6 evt on", 0, 0, 8'd4, 8'h00, 1);
    op("R6 check on", 0, 0, 8'd4, 8'h00, 0);
    // R7 event with clearing read
    op("R7 collide", 0, 1, 8'd4, 8'h00, 1);
    @(negedge clk); addr = 4; #2;
    chk("R7 flag kept", {7'b0, rdata[2]}, 8'h01);
    op("R6 clear", 0, 1, 8'd4, 8'h00, 0);
    // R11
    @(negedge clk); ack_in = 1; addr = 4; #2;
    chk("R11 ack high", {7'b0, rdata[1]}, 8'h01);
    ack_in = 0; #1 chk("R11 ack low", {7'b0, rdata[1]}, 8'h00);
    // R8 R9 hold timers
    @(negedge clk); ovt_flt = 1;
    peek_diag("R8 ovt level", 3, 1);
    ticks(50);
    @(negedge clk); ovt_flt = 0;
    ticks(HOLD - 1);
    peek_diag("R9 ovt held", 3, 1);
    ticks(1);
    peek_diag("R9 ovt dropped", 3, 0);
    @(negedge clk); ovl_flt = 2'b10;
    peek_diag("R8 ovl1 level", 5, 1);
    peek_diag("R8 ovl0 quiet", 4, 0);
    @(negedge clk); ovl_flt = 2'b00;
    ticks(HOLD - 1);
    peek_diag("R9 ovl1 held", 5, 1);
    ticks(1);
    peek_diag("R9 ovl1 dropped", 5, 0);
    @(negedge clk); uvd_flt = 2'b01;
    peek_diag("R8 uvd0 level", 6, 1);
    @(negedge clk); uvd_flt = 2'b00;
    ticks(10);
    @(negedge clk); uvd_flt = 2'b01;
    @(negedge clk); uvd_flt = 2'b00;
    ticks(HOLD - 1);
    peek_diag("R9 uvd0 reload held", 6, 1);
    ticks(1);
    peek_diag("R9 uvd0 dropped", 6, 0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      in_status = 1'($urandom);
      ack_in = 1'($urandom);
      op("RND", ($urandom % 3) == 0, ($urandom % 2) == 0, 8'($urandom % 8), 8'($urandom),
         ($urandom % 4) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule